// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees an I2C bus that a slave is holding stuck with SDA low. A recovery request is taken only when the block is idle and the bus-busy indication is still high. The block then does four things in turn. It raises a level that tells the receive path to answer with NACK. It toggles SCL directly with a fixed train of clock pulses, each one pulled low and then released, while SDA is left released so the slave can shift out what remains of its byte. It then forms a STOP condition. Last, it gives a one-cycle completion pulse, after which the surrounding controller is reinitialised.

Phase timing comes from one of two sources. The first is a count of system clock cycles per microsecond. The second is an external one-microsecond tick, chosen with `EXT_TICK`. Every SCL low phase and every SCL released phase lasts `PHASE_US` microseconds. The outputs are open-drain pull-down enables, so a 1 means the line is driven low.

Top module: `i2c_bus_clear`

## Requirements
- R1: While rst_ni is low and in the first cycle after reset, scl_low_o, sda_low_o, nack_o and done_o are all 0.
- R2: When the block is idle and req_i and bus_busy_i are both 1 at a clock edge, nack_o is 1 from the next cycle. SCL and SDA stay released for that one cycle.
- R3: A request with bus_busy_i at 0 is ignored. All outputs stay 0.
- R4: The train holds exactly NUM_PULSES (default 9) SCL pulses. Each pulse has scl_low_o at 1 first, then scl_low_o at 0.
- R5: Each SCL low phase and each SCL released phase lasts PHASE_US microseconds. In count mode that is PHASE_US*CYC_PER_US clock cycles. In tick mode it is PHASE_US pulses of tick_i.
- R6: sda_low_o is 0 for the whole pulse train.
- R7: After the last released phase, the STOP is formed in three steps. SCL and SDA are both pulled low for one phase. SCL is released with SDA still pulled for one phase. SDA is then released while SCL stays released.
- R8: done_o is a single-cycle pulse in the cycle SDA is released. nack_o is 0 in that cycle. The block is idle in the next cycle.
- R9: A request that arrives while a sequence is running, including its done cycle, is ignored and does not alter the running sequence.
- R10: nack_o stays 1 from the first cycle of the sequence to the last cycle of the STOP, and is 1 whenever SCL or SDA is pulled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Recovery request |
| bus_busy_i | input | 1 | Bus-busy indication; a request is taken only while it is high |
| tick_i | input | 1 | One-microsecond tick, used when EXT_TICK is 1 |
| scl_low_o | output | 1 | Pull SCL low |
| sda_low_o | output | 1 | Pull SDA low |
| nack_o | output | 1 | Receive path answers with NACK |
| nack_o |  |  |  |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A request sampled at edge k shows up as nack_o in the cycle after edge k. With a phase of P cycles, SCL low phase n (counting from 0) starts 1+2nP cycles after the accepting edge. The STOP setup phase starts at 1+18P, SCL is released over SDA at 1+19P, and done_o appears at 1+20P.

The bench keeps a running sequence offset that advances one step at every edge. At each falling edge it compares all four outputs with a function of that offset, so every phase boundary is checked in the exact cycle it is due. Requests, including those that must be ignored, are drawn at random and applied at falling edges. The bench also counts rising SCL releases before the STOP and compares the total at done.

// File: rtl/i2c_bc_pkg.sv
package i2c_bc_pkg;
  typedef enum logic [2:0] {
    BC_IDLE,
    BC_NACK,
    BC_LOW,
    BC_HIGH,
    BC_STOP_LOW,
    BC_STOP_HIGH,
    BC_DONE
  } bc_state_e;
endpackage

// File: rtl/i2c_bc_timer.sv
module i2c_bc_timer #(
  parameter int CYC_PER_US = 100,
  parameter int PHASE_US   = 20,
  parameter bit EXT_TICK   = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam int UW = (PHASE_US > 1) ? $clog2(PHASE_US) : 1;

  logic [PW-1:0] pre_q;
  logic [UW-1:0] us_q;
  logic          pre_wrap;
  logic          step;
  logic          us_last;

  assign pre_wrap = (pre_q == PW'(CYC_PER_US - 1));
  // tick source: external microsecond strobe or local prescaler
  assign step     = EXT_TICK ? tick_i : pre_wrap;
  assign us_last  = (us_q == UW'(PHASE_US - 1));
  assign expire_o = step && us_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pre_q <= '0;
    else if (restart_i || EXT_TICK) pre_q <= '0;
    else if (pre_wrap)              pre_q <= '0;
    else                            pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        us_q <= '0;
    else if (restart_i) us_q <= '0;
    else if (step)      us_q <= us_last ? '0 : us_q + 1'b1;
  end
endmodule

// File: rtl/i2c_bc_ctrl.sv
module i2c_bc_ctrl
  import i2c_bc_pkg::*;
#(
  parameter int NUM_PULSES = 9
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_i,
  input  logic      bus_busy_i,
  input  logic      expire_i,
  output bc_state_e state_o,
  output logic      restart_o
);
  localparam int CW = (NUM_PULSES > 1) ? $clog2(NUM_PULSES) : 1;

  bc_state_e     state_q, state_d;
  logic [CW-1:0] pulse_q, pulse_d;

  always_comb begin
    state_d = state_q;
    pulse_d = pulse_q;
    unique case (state_q)
      BC_IDLE:      if (req_i && bus_busy_i) state_d = BC_NACK;
      BC_NACK:      state_d = BC_LOW;
      BC_LOW:       if (expire_i) state_d = BC_HIGH;
      BC_HIGH: begin
        if (expire_i) begin
          if (pulse_q == CW'(NUM_PULSES - 1)) begin
            state_d = BC_STOP_LOW;
            pulse_d = '0;
          end else begin
            state_d = BC_LOW;
            pulse_d = pulse_q + 1'b1;
          end
        end
      end
      BC_STOP_LOW:  if (expire_i) state_d = BC_STOP_HIGH;
      BC_STOP_HIGH: if (expire_i) state_d = BC_DONE;
      BC_DONE:      state_d = BC_IDLE;
      default:      state_d = BC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BC_IDLE;
      pulse_q <= '0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
    end
  end

  assign state_o   = state_q;
  assign restart_o = (state_d != state_q);
endmodule

// File: rtl/i2c_bc_drive.sv
module i2c_bc_drive
  import i2c_bc_pkg::*;
(
  input  bc_state_e state_i,
  output logic      scl_low_o,
  output logic      sda_low_o,
  output logic      nack_o,
  output logic      done_o
);
  always_comb begin
    scl_low_o = 1'b0;
    sda_low_o = 1'b0;
    nack_o    = 1'b0;
    done_o    = 1'b0;
    unique case (state_i)
      BC_IDLE:      ;
      BC_NACK:      nack_o = 1'b1;
      BC_LOW:       begin nack_o = 1'b1; scl_low_o = 1'b1; end
      BC_HIGH:      nack_o = 1'b1;
      BC_STOP_LOW:  begin nack_o = 1'b1; scl_low_o = 1'b1; sda_low_o = 1'b1; end
      BC_STOP_HIGH: begin nack_o = 1'b1; sda_low_o = 1'b1; end
      BC_DONE:      done_o = 1'b1;
      default:      ;
    endcase
  end
endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear
  import i2c_bc_pkg::*;
#(
  parameter int CYC_PER_US = 100,
  parameter int PHASE_US   = 20,
  parameter int NUM_PULSES = 9,
  parameter bit EXT_TICK   = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic bus_busy_i,
  input  logic tick_i,
  output logic scl_low_o,
  output logic sda_low_o,
  output logic nack_o,
  output logic done_o
);
  bc_state_e state;
  logic      restart;
  logic      expire;

  i2c_bc_timer #(
    .CYC_PER_US(CYC_PER_US),
    .PHASE_US  (PHASE_US),
    .EXT_TICK  (EXT_TICK)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .tick_i   (tick_i),
    .expire_o (expire)
  );

  i2c_bc_ctrl #(
    .NUM_PULSES(NUM_PULSES)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .bus_busy_i(bus_busy_i),
    .expire_i  (expire),
    .state_o   (state),
    .restart_o (restart)
  );

  i2c_bc_drive u_drive (
    .state_i  (state),
    .scl_low_o(scl_low_o),
    .sda_low_o(sda_low_o),
    .nack_o   (nack_o),
    .done_o   (done_o)
  );
endmodule

// File: rtl/i2c_bus_clear_chk.sv
module i2c_bus_clear_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic bus_busy_i,
  input logic scl_low_o,
  input logic sda_low_o,
  input logic nack_o,
  input logic done_o
);
  // R2
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && bus_busy_i && !nack_o && !done_o) |=> (nack_o && !scl_low_o && !sda_low_o));

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(req_i && bus_busy_i) && !nack_o && !done_o) |=> (!nack_o && !scl_low_o && !sda_low_o));

  // R7
  stop_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_low_o) |-> scl_low_o);

  // R7
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_low_o) |-> (!scl_low_o && done_o));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !nack_o));

  // R10
  nack_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_low_o || sda_low_o) |-> nack_o);
endmodule

bind i2c_bus_clear i2c_bus_clear_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .bus_busy_i(bus_busy_i),
  .scl_low_o (scl_low_o),
  .sda_low_o (sda_low_o),
  .nack_o    (nack_o),
  .done_o    (done_o)
);

// File: tb/i2c_bus_clear_test.sv
module i2c_bus_clear_test;
  localparam int CLK_PERIOD = 10;
  localparam int CYC_US     = 2;
  localparam int PH_US      = 3;
  localparam int NPULSE     = 9;
  localparam int P          = CYC_US * PH_US;
  localparam int TRAIN_END  = 2 * NPULSE * P;
  localparam int SEQ_END    = TRAIN_END + 2 * P + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic busy = 1'b0;
  logic scl_low, sda_low, nack, done;

  int checks = 0;
  int errors = 0;
  int seq_t = -1;
  int pulses = 0;
  logic prev_scl = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_bus_clear #(
    .CYC_PER_US(CYC_US),
    .PHASE_US  (PH_US),
    .NUM_PULSES(NPULSE),
    .EXT_TICK  (1'b0)
  ) uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .req_i     (req),
    .bus_busy_i(busy),
    .tick_i    (1'b0),
    .scl_low_o (scl_low),
    .sda_low_o (sda_low),
    .nack_o    (nack),
    .done_o    (done)
  );

  // expected {scl, sda, nack, done} at sequence offset t (-1 = idle)
  function automatic logic [3:0] exp_out(int t);
    if (t < 0)              return 4'b0000;
    if (t == 0)             return 4'b0010;
    if (t <= TRAIN_END)     return (((t - 1) / P) % 2 == 0) ? 4'b1010 : 4'b0010;
    if (t <= TRAIN_END + P) return 4'b1110;
    if (t < SEQ_END)        return 4'b0110;
    return 4'b0001;
  endfunction

  function automatic string tag_of(int t, logic r, logic b);
    if (t < 0)              return (r && !b) ? "R3" : "R1";
    if (t == 0)             return "R2";
    if (r)                  return "R9";
    if (t <= TRAIN_END)     return ((t % 2) == 0) ? "R5" : "R6";
    if (t < SEQ_END)        return "R7";
    return "R8";
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b (scl,sda,nack,done) t=%0d", tag, act, exp, seq_t);
    end
  endtask

  logic last_req, last_busy;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2c01));
    last_req = 1'b0;
    last_busy = 1'b0;
    #(CLK_PERIOD * 3 + 1);
    check("R1", {scl_low, sda_low, nack, done}, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {scl_low, sda_low, nack, done}, 4'b0000);

    for (int cyc = 0; cyc < 5000; cyc++) begin
      // check current cycle against model
      check(tag_of(seq_t, last_req, last_busy), {scl_low, sda_low, nack, done}, exp_out(seq_t));
      if (seq_t == 0) pulses = 0;
      if (seq_t > 0 && prev_scl && !scl_low && !sda_low && seq_t <= TRAIN_END + 1) pulses++;
      if (seq_t == SEQ_END) check("R4", 4'(pulses), 4'(NPULSE));
      prev_scl = scl_low;

      // choose stimulus for the next edge
      if (seq_t == SEQ_END) begin
        req = 1'b1; busy = 1'b1;           // request in done cycle: ignored
      end else if (seq_t == -1) begin
        req  = ($urandom_range(0, 3) == 0);
        busy = ($urandom_range(0, 2) != 0);
      end else begin
        req  = ($urandom_range(0, 15) == 0);
        busy = $urandom_range(0, 1) != 0;
      end
      last_req  = req;
      last_busy = busy;

      // advance model across the edge
      if (seq_t == -1) begin
        if (req && busy) seq_t = 0;
      end else if (seq_t == SEQ_END) begin
        seq_t = -1;
      end else begin
        seq_t++;
      end
      @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule